// File: doc/BRIEF.md
# Scan-Sampled On-Delay Timer

This block is an on-delay timer whose state moves only when a scan strobe arrives, not on every clock edge. A free-running millisecond counter inside the block provides the time reference. On each strobe the timer subtracts a stored millisecond timestamp from the current count. It converts that difference into whole units of the selected timebase and adds them to an accumulator. It then stores the current count as the new timestamp and compares the accumulator with a preset.

The timestamp is a short field, 9 bits of milliseconds by default, so elapsed time is taken modulo 512 ms. A controller that scans less often than the wrap period loses whole wrap periods without any sign of it. Done is only re-evaluated when a strobe arrives. The moment it rises can therefore trail the true expiry by up to almost one scan interval, and that lag varies from scan to scan.

Top module: `scan_ton_timer`

## Requirements
- R1: After reset the accumulator reads 0 and the enable, timing and done flags are all 0.
- R2: Accumulator and flags change only on a clock edge where `scan_i` is high. Toggling `rung_i` or `preset_i` between strobes leaves every output unchanged.
- R3: A strobe with `rung_i` low clears the accumulator and all three flags and discards any stored remainder.
- R4: The first strobe with `rung_i` high after the flags were clear sets enable, sets timing (unless R11 applies) and leaves the accumulator at 0. No elapsed time is added on this strobe.
- R5: Each later strobe with `rung_i` high adds the whole timebase units elapsed since the previous strobe to the accumulator.
- R6: `tb_sel_i` encodes the unit size: 0 selects 1 ms, 1 selects 10 ms, and 2 or 3 select 1 s. Milliseconds left over after converting to units are carried into the next strobe, so no fraction of a unit is lost.
- R7: When the updated accumulator is greater than or equal to the preset, done goes to 1, timing goes to 0, and the accumulator is clamped to the preset.
- R8: While done is set, further true-rung strobes keep done at 1 and keep the accumulator equal to the preset.
- R9: Elapsed time is measured modulo 2^REF_W ms (512 ms by default). A strobe gap of 600 ms adds 88 ms, and a gap of exactly 512 ms adds nothing.
- R10: Lowering the preset below the accumulator between strobes does not raise done. Done is raised by the next strobe.
- R11: With a preset of 0, the first true-rung strobe sets done and enable and leaves timing at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scan_i | input | 1 | One-cycle scan strobe |
| rung_i | input | 1 | Rung condition sampled with the strobe |
| preset_i | input | ACC_W | Preset in timebase units |
| tb_sel_i | input | 2 | Timebase select (R6 encoding) |
| acc_o | output | ACC_W | Accumulator in timebase units |
| en_o | output | 1 | Enable flag |
| timing_o | output | 1 | Timing flag |
| done_o | output | 1 | Done flag |

## Verification
The bench builds the timer with `CYC_PER_MS` = 4, so one millisecond lasts four clocks. The 512 ms wrap and the 1 s timebase then fit in a few thousand cycles. `REF_W` and `ACC_W` keep their default values, so the wrap arithmetic under test is the one the default build uses. Strobe gaps are whole multiples of four clocks, which makes every elapsed count exact no matter where the prescaler sits.

// File: rtl/scan_ton_pkg.sv
package scan_ton_pkg;

   typedef enum logic [1:0] {
      TB_1MS  = 2'd0,
      TB_10MS = 2'd1,
      TB_1S   = 2'd2,
      TB_1S_B = 2'd3
   } tb_sel_t;

   localparam int MAX_REM = 999;
   localparam int REM_W   = 10;

   function automatic int tot_width(input int ref_w);
      return $clog2(MAX_REM + (1 << ref_w) + 1);
   endfunction

endpackage

// File: rtl/ms_timebase.sv
module ms_timebase #(
   parameter int REF_W      = 9,
   parameter int CYC_PER_MS = 50000
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [REF_W-1:0] now_ms
);

   logic ms_tick;

   generate
      if (CYC_PER_MS < 1) begin : g_bad_cyc
         $error("CYC_PER_MS must be at least 1");
      end
      if (CYC_PER_MS == 1) begin : g_direct
         assign ms_tick = 1'b1;
      end else begin : g_prescale
         localparam int PS_W = $clog2(CYC_PER_MS);
         localparam logic [PS_W-1:0] PS_LAST = PS_W'(CYC_PER_MS - 1);
         logic [PS_W-1:0] ps_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              ps_q <= '0;
            else if (ps_q == PS_LAST) ps_q <= '0;
            else                     ps_q <= ps_q + 1'b1;
         end
         assign ms_tick = (ps_q == PS_LAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       now_ms <= '0;
      else if (ms_tick) now_ms <= now_ms + 1'b1;
   end

endmodule

// File: rtl/tick_scaler.sv
module tick_scaler
   import scan_ton_pkg::*;
#(
   parameter int REF_W = 9,
   localparam int TOT_W = tot_width(REF_W)
) (
   input  logic [REF_W-1:0] now_ms,
   input  logic [REF_W-1:0] ref_ms,
   input  logic [REM_W-1:0] rem_in,
   input  tb_sel_t          sel,
   output logic [TOT_W-1:0] units,
   output logic [REM_W-1:0] rem_out
);

   logic [REF_W-1:0] delta;
   logic [TOT_W-1:0] total;

   // modulo-2^REF_W difference: gaps beyond the wrap lose whole periods
   assign delta = now_ms - ref_ms;
   assign total = TOT_W'(rem_in) + TOT_W'(delta);

   always_comb begin
      unique case (sel)
         TB_1MS: begin
            units   = total;
            rem_out = '0;
         end
         TB_10MS: begin
            units   = total / TOT_W'(10);
            rem_out = REM_W'(total % TOT_W'(10));
         end
         default: begin
            units   = total / TOT_W'(1000);
            rem_out = REM_W'(total % TOT_W'(1000));
         end
      endcase
   end

endmodule

// File: rtl/scan_ton_timer.sv
module scan_ton_timer
   import scan_ton_pkg::*;
#(
   parameter int ACC_W      = 16,
   parameter int REF_W      = 9,
   parameter int CYC_PER_MS = 50000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scan_i,
   input  logic             rung_i,
   input  logic [ACC_W-1:0] preset_i,
   input  logic [1:0]       tb_sel_i,
   output logic [ACC_W-1:0] acc_o,
   output logic             en_o,
   output logic             timing_o,
   output logic             done_o
);

   localparam int TOT_W = tot_width(REF_W);

   generate
      if (REF_W < 2 || REF_W > 16) begin : g_bad_ref
         $error("REF_W out of range");
      end
      if (ACC_W < TOT_W) begin : g_bad_acc
         $error("ACC_W too narrow for one scan increment");
      end
   endgenerate

   logic [REF_W-1:0] now_ms, ref_q;
   logic [REM_W-1:0] rem_q, rem_nxt;
   logic [TOT_W-1:0] units;
   logic [ACC_W-1:0] acc_q;
   logic [ACC_W:0]   acc_sum;
   logic             en_q, tt_q, dn_q;

   ms_timebase #(.REF_W(REF_W), .CYC_PER_MS(CYC_PER_MS)) u_tbase (
      .clk    (clk),
      .rst_n  (rst_n),
      .now_ms (now_ms)
   );

   tick_scaler #(.REF_W(REF_W)) u_scale (
      .now_ms  (now_ms),
      .ref_ms  (ref_q),
      .rem_in  (rem_q),
      .sel     (tb_sel_t'(tb_sel_i)),
      .units   (units),
      .rem_out (rem_nxt)
   );

   assign acc_sum = {1'b0, acc_q} + (ACC_W+1)'(units);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         ref_q <= '0;
         rem_q <= '0;
         en_q  <= 1'b0;
         tt_q  <= 1'b0;
         dn_q  <= 1'b0;
      end else if (scan_i) begin
         ref_q <= now_ms;
         if (!rung_i) begin
            acc_q <= '0;
            rem_q <= '0;
            en_q  <= 1'b0;
            tt_q  <= 1'b0;
            dn_q  <= 1'b0;
         end else if (!en_q) begin
            acc_q <= '0;
            rem_q <= '0;
            en_q  <= 1'b1;
            dn_q  <= (preset_i == '0);
            tt_q  <= (preset_i != '0);
         end else if (dn_q) begin
            acc_q <= preset_i;
            rem_q <= '0;
         end else begin
            rem_q <= rem_nxt;
            if (acc_sum >= {1'b0, preset_i}) begin
               acc_q <= preset_i;
               dn_q  <= 1'b1;
               tt_q  <= 1'b0;
            end else begin
               acc_q <= acc_sum[ACC_W-1:0];
            end
         end
      end
   end

   assign acc_o    = acc_q;
   assign en_o     = en_q;
   assign timing_o = tt_q;
   assign done_o   = dn_q;

   assert_hold_between_scans_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !scan_i |=> $stable(acc_q) && $stable(en_q) && $stable(tt_q) && $stable(dn_q));

   assert_clear_on_false_R3: assert property (@(posedge clk) disable iff (!rst_n)
      scan_i && !rung_i |=> acc_q == '0 && !en_q && !tt_q && !dn_q && rem_q == '0);

   assert_first_scan_R4: assert property (@(posedge clk) disable iff (!rst_n)
      scan_i && rung_i && !en_q |=> en_q && acc_q == '0);

   assert_done_excludes_timing_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dn_q |-> !tt_q && en_q);

   assert_saturated_R8: assert property (@(posedge clk) disable iff (!rst_n)
      scan_i && rung_i && dn_q |=> dn_q && acc_q == $past(preset_i));

   assert_remainder_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rem_q <= REM_W'(MAX_REM));

endmodule

// File: tb/test_scan_ton_timer.sv
module test_scan_ton_timer;

   localparam int CLK_PERIOD = 10;
   localparam int CYC        = 4;
   localparam int ACC_W      = 16;
   localparam int NV         = 10;

   // table: rung, gap in ms, preset, tb_sel, expected acc, en, tt, dn
   localparam int V_RUNG[NV] = '{0, 1, 1, 1, 1, 1, 0, 1, 1, 1};
   localparam int V_GAP [NV] = '{1, 3, 5, 7, 10, 30, 2, 4, 19, 1};
   localparam int V_ACC [NV] = '{0, 0, 5, 12, 20, 20, 0, 0, 19, 20};
   localparam int V_EN  [NV] = '{0, 1, 1, 1, 1, 1, 0, 1, 1, 1};
   localparam int V_TT  [NV] = '{0, 1, 1, 1, 0, 0, 0, 1, 1, 0};
   localparam int V_DN  [NV] = '{0, 0, 0, 0, 1, 1, 0, 0, 0, 1};

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             scan_i = 1'b0;
   logic             rung_i = 1'b0;
   logic [ACC_W-1:0] preset_i = '0;
   logic [1:0]       tb_sel_i = 2'd0;
   logic [ACC_W-1:0] acc_o;
   logic             en_o, timing_o, done_o;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   scan_ton_timer #(.ACC_W(ACC_W), .REF_W(9), .CYC_PER_MS(CYC)) i_scan_ton_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .scan_i   (scan_i),
      .rung_i   (rung_i),
      .preset_i (preset_i),
      .tb_sel_i (tb_sel_i),
      .acc_o    (acc_o),
      .en_o     (en_o),
      .timing_o (timing_o),
      .done_o   (done_o)
   );

   task automatic check(input string req, input int acc, input bit en, input bit tt, input bit dn);
      checks++;
      if (acc_o !== ACC_W'(acc) || en_o !== en || timing_o !== tt || done_o !== dn) begin
         failures++;
         $display("FAIL %s: acc=%0d en=%0b tt=%0b dn=%0b expected acc=%0d en=%0b tt=%0b dn=%0b",
                  req, acc_o, en_o, timing_o, done_o, acc, en, tt, dn);
      end
   endtask

   // strobe placed gap_ms whole milliseconds after the previous strobe edge
   task automatic scan_after(input int gap_ms, input bit rung);
      repeat (gap_ms * CYC - 1) @(negedge clk);
      rung_i = rung;
      scan_i = 1'b1;
      @(negedge clk);
      scan_i = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset", 0, 0, 0, 0);

      // table walk, 1 ms timebase, preset 20: R3 R4 R5 R7 R8
      preset_i = 16'd20;
      tb_sel_i = 2'd0;
      for (int i = 0; i < NV; i++) begin
         scan_after(V_GAP[i], V_RUNG[i][0]);
         check($sformatf("R5 R7 R8 vector %0d", i), V_ACC[i], V_EN[i][0], V_TT[i][0], V_DN[i][0]);
      end

      // R2 and R10: preset lowered and rung toggled between scans
      scan_after(1, 1'b0);
      scan_after(1, 1'b1);
      scan_after(15, 1'b1);
      check("R5 acc 15", 15, 1, 1, 0);
      preset_i = 16'd10;
      rung_i = 1'b0;
      repeat (9) @(negedge clk);
      check("R10 no done before scan", 15, 1, 1, 0);
      rung_i = 1'b1;
      repeat (3) @(negedge clk);
      check("R2 rung toggle ignored", 15, 1, 1, 0);
      scan_after(1, 1'b1);
      check("R10 done at next scan", 10, 1, 0, 1);

      // R6: 10 ms timebase with remainder carry
      preset_i = 16'd100;
      tb_sel_i = 2'd1;
      scan_after(1, 1'b0);
      check("R3 clear", 0, 0, 0, 0);
      scan_after(1, 1'b1);
      check("R4 first scan", 0, 1, 1, 0);
      scan_after(15, 1'b1);
      check("R6 10ms 15", 1, 1, 1, 0);
      scan_after(7, 1'b1);
      check("R6 10ms carry 12", 2, 1, 1, 0);
      scan_after(8, 1'b1);
      check("R6 10ms carry 10", 3, 1, 1, 0);

      // R6: 1 s timebase, encoding 2 then 3
      preset_i = 16'd2;
      tb_sel_i = 2'd2;
      scan_after(1, 1'b0);
      scan_after(1, 1'b1);
      scan_after(400, 1'b1);
      scan_after(400, 1'b1);
      check("R6 1s under one unit", 0, 1, 1, 0);
      tb_sel_i = 2'd3;
      scan_after(300, 1'b1);
      check("R6 1s carry to one unit", 1, 1, 1, 0);

      // R9: reference wrap at 512 ms
      preset_i = 16'd1000;
      tb_sel_i = 2'd0;
      scan_after(1, 1'b0);
      scan_after(1, 1'b1);
      scan_after(600, 1'b1);
      check("R9 600ms wraps to 88", 88, 1, 1, 0);
      scan_after(512, 1'b1);
      check("R9 512ms adds nothing", 88, 1, 1, 0);

      // R11: zero preset
      preset_i = 16'd0;
      scan_after(1, 1'b0);
      scan_after(1, 1'b1);
      check("R11 zero preset", 0, 1, 0, 1);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule